// File: doc/BRIEF.md
# Programmable Hysteresis Switchpoint Comparator

This block converts a signed magnetic-field estimate into a two-state switch output. A 5-bit calibration code places the operate threshold at `BASE + code * STEP`. The release threshold always sits a fixed `HYS` below the operate threshold. The output rises when a sample exceeds the operate threshold and falls when a sample drops below the release threshold. Between the two thresholds, the output keeps its state. Positive values mean south polarity, so a stronger south field or a weaker north field pushes the output toward high.

Field samples arrive on a valid/ready stream. After reset the output is forced high for a power-on interval of `POR_CYC` cycles. During that interval `fld_ready` is low, so a valid sample is not consumed and has no effect. Once the interval is over, `fld_ready` stays high and the block takes one sample per cycle with no back-pressure. A sample is consumed on any clock edge where both `fld_valid` and `fld_ready` are high. The code input is plain control: it is read only when a sample is consumed.

Top module: `hyst_switch`

## Requirements
- R1: A consumed sample strictly greater than the operate threshold `BASE + code*STEP` sets `sw_out` to 1. `code` is read as an unsigned 5-bit value (0..31).
- R2: A consumed sample strictly less than the release threshold `BASE + code*STEP - HYS` sets `sw_out` to 0.
- R3: A consumed sample equal to either threshold, or lying between them, leaves `sw_out` unchanged.
- R4: `fld_data` is two's-complement. Negative (north) fields and zero field drive `sw_out` to 0 whenever the release threshold is positive.
- R5: For the `POR_CYC` clock edges after reset is released, `sw_out` is 1 and `fld_ready` is 0. Valid samples offered during this interval do not change `sw_out`.
- R6: `fld_ready` becomes 1 on the `POR_CYC`-th edge after reset release and stays 1 until the next reset.
- R7: A change of `code` with no consumed sample leaves `sw_out` unchanged. The next consumed sample is compared against the thresholds of the new code.
- R8: `sw_out` changes only on the edge that consumes a sample, so it shows the result one cycle after that sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fld_valid | input | 1 | A field sample is present |
| fld_ready | output | 1 | Block accepts samples (low during the power-on interval) |
| fld_data | input | FW | Signed field sample, positive = south |
| code | input | CW | Operate-point step code |
| sw_out | output | 1 | Switch state, 1 = high |

## Verification
Each consumed sample is due on `sw_out` in the cycle after it is presented. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The power-on release is due on the `POR_CYC`-th rising edge after reset ends, so `fld_ready` is checked after every edge up to that point. For code changes made without a sample, the output is read one full cycle later to show that it did not move.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic {
    SW_LOW  = 1'b0,
    SW_HIGH = 1'b1
  } sw_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hsw_thresh.sv
module hsw_thresh #(
  parameter int CW   = 5,
  parameter int TW   = 14,
  parameter int BASE = 300,
  parameter int STEP = 16,
  parameter int HYS  = 15
) (
  input  logic [CW-1:0]        code,
  output logic signed [TW-1:0] op_th,
  output logic signed [TW-1:0] rl_th
);
  localparam logic signed [TW-1:0] BASE_S = TW'(BASE);
  localparam logic signed [TW-1:0] STEP_S = TW'(STEP);
  localparam logic signed [TW-1:0] HYS_S  = TW'(HYS);

  logic signed [TW-1:0] code_s;
  logic signed [TW-1:0] offs;

  always_comb begin
    code_s = signed'({{(TW-CW){1'b0}}, code});
    offs   = code_s * STEP_S;
    op_th  = BASE_S + offs;
    rl_th  = op_th - HYS_S;
  end
endmodule

// File: rtl/hsw_por.sv
module hsw_por #(
  parameter int unsigned POR_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned CNTW = hsw_pkg::cnt_width(POR_CYC);
  localparam logic [CNTW-1:0] LIMIT = CNTW'(POR_CYC);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/hsw_core.sv
module hsw_core #(
  parameter int FW = 12,
  parameter int TW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic signed [FW-1:0] fld,
  input  logic signed [TW-1:0] op_th,
  input  logic signed [TW-1:0] rl_th,
  output logic                 sw
);
  import hsw_pkg::*;

  logic signed [TW-1:0] fld_x;
  sw_state_e st_q, st_d;

  assign fld_x = signed'({{(TW-FW){fld[FW-1]}}, fld});

  always_comb begin
    st_d = st_q;
    if (take) begin
      if (fld_x > op_th)      st_d = SW_HIGH;
      else if (fld_x < rl_th) st_d = SW_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SW_HIGH;
    else        st_q <= st_d;
  end

  assign sw = (st_q == SW_HIGH);
endmodule

// File: rtl/hyst_switch.sv
module hyst_switch #(
  parameter int          FW      = 12,
  parameter int          CW      = 5,
  parameter int          BASE    = 300,
  parameter int          STEP    = 16,
  parameter int          HYS     = 15,
  parameter int unsigned POR_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fld_valid,
  output logic                 fld_ready,
  input  logic signed [FW-1:0] fld_data,
  input  logic [CW-1:0]        code,
  output logic                 sw_out
);
  localparam int TW = FW + 2;

  logic signed [TW-1:0] op_th;
  logic signed [TW-1:0] rl_th;
  logic                 por_done;
  logic                 take;

  hsw_thresh #(.CW(CW), .TW(TW), .BASE(BASE), .STEP(STEP), .HYS(HYS)) u_thresh (
    .code (code),
    .op_th(op_th),
    .rl_th(rl_th)
  );

  hsw_por #(.POR_CYC(POR_CYC)) u_por (
    .clk  (clk),
    .rst_n(rst_n),
    .done (por_done)
  );

  assign fld_ready = por_done;
  assign take      = fld_valid && por_done;

  hsw_core #(.FW(FW), .TW(TW)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .fld  (fld_data),
    .op_th(op_th),
    .rl_th(rl_th),
    .sw   (sw_out)
  );
endmodule

// File: rtl/hyst_switch_chk.sv
module hyst_switch_chk #(
  parameter int FW = 12,
  parameter int TW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fld_valid,
  input logic                 fld_ready,
  input logic signed [FW-1:0] fld_data,
  input logic                 sw_out,
  input logic signed [TW-1:0] op_th,
  input logic signed [TW-1:0] rl_th
);
  logic signed [TW-1:0] fx;
  assign fx = signed'({{(TW-FW){fld_data[FW-1]}}, fld_data});

  // R1: a rise needs a consumed sample above the operate threshold
  a_r1_rise_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_out) |-> $past(fld_valid && fld_ready && (fx > op_th)));

  // R2: a fall needs a consumed sample below the release threshold
  a_r2_fall_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_out) |-> $past(fld_valid && fld_ready && (fx < rl_th)));

  // R5: output held high while not ready
  a_r5_por_high: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_ready |-> sw_out);

  // R6: ready never drops again
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fld_ready) |-> fld_ready);

  // R8: no consumed sample, no change
  a_r8_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fld_valid && fld_ready) |-> $stable(sw_out));
endmodule

bind hyst_switch hyst_switch_chk #(.FW(FW), .TW(FW + 2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fld_valid(fld_valid),
  .fld_ready(fld_ready),
  .fld_data (fld_data),
  .sw_out   (sw_out),
  .op_th    (op_th),
  .rl_th    (rl_th)
);

// File: tb/hyst_switch_bench.sv
`timescale 1ns/100ps
module hyst_switch_bench;
  localparam int FW = 12, CW = 5, BASE = 300, STEP = 16, HYS = 15;
  localparam int POR_CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fld_valid = 1'b0;
  logic fld_ready;
  logic signed [FW-1:0] fld_data = '0;
  logic [CW-1:0] code = '0;
  logic sw_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit model = 1'b1;

  always #2.5 clk = ~clk;

  hyst_switch #(.FW(FW), .CW(CW), .BASE(BASE), .STEP(STEP), .HYS(HYS), .POR_CYC(POR_CYC)) u_hyst_switch (
    .clk(clk), .rst_n(rst_n), .fld_valid(fld_valid), .fld_ready(fld_ready),
    .fld_data(fld_data), .code(code), .sw_out(sw_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one consumed sample; result read one cycle later
  task automatic sample(input int f, input int c, input string req);
    int op;
    fld_valid = 1'b1;
    fld_data  = FW'(f);
    code      = CW'(c);
    op = BASE + c * STEP;
    if (f > op) model = 1'b1;
    else if (f < op - HYS) model = 1'b0;
    @(posedge clk);
    @(negedge clk);
    fld_valid = 1'b0;
    check(req, int'(sw_out), int'(model));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset sw_out", int'(sw_out), 1);
    check("R5 reset ready", int'(fld_ready), 0);
    rst_n = 1'b1;
    // offer a strong north sample during the hold interval
    fld_valid = 1'b1;
    fld_data  = FW'(-200);
    for (int i = 1; i <= POR_CYC; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i < POR_CYC) begin
        check("R5 hold ready low", int'(fld_ready), 0);
        check("R5 hold sw_out high", int'(sw_out), 1);
      end else begin
        check("R6 ready rises at POR_CYC", int'(fld_ready), 1);
        check("R5 sample during hold ignored", int'(sw_out), 1);
      end
    end
    fld_valid = 1'b0;
    model = 1'b1;

    // R4: north and zero fields go low
    sample(-200, 0, "R4 north field low");
    sample(0, 0, "R4 zero field low");
    sample(-2048, 31, "R4 max north low");

    // sweep every code across both thresholds
    for (int c = 0; c < 32; c++) begin
      int op;
      op = BASE + c * STEP;
      sample(0, c, "R4 zero low");
      sample(op, c, "R3 equal operate holds low");
      sample(op - HYS, c, "R3 equal release holds low");
      sample(op + 1, c, "R1 above operate high");
      check("R6 ready stays", int'(fld_ready), 1);
      sample(op, c, "R3 equal operate holds high");
      sample(op - HYS, c, "R3 equal release holds high");
      sample(op - 7, c, "R3 inside band holds");
      sample(op - HYS - 1, c, "R2 below release low");
      sample(op - 7, c, "R3 inside band holds low");
    end

    // R7: code change without sample keeps output, next sample uses new code
    sample(400, 0, "R7 prepare high");
    code = CW'(31);
    @(posedge clk);
    @(negedge clk);
    check("R7 code change alone no effect", int'(sw_out), 1);
    sample(400, 31, "R7 new code applied");
    check("R7 new code output low", int'(sw_out), 0);

    // R8: valid low keeps output even with a high field
    fld_data = FW'(2000);
    repeat (3) @(negedge clk);
    check("R8 no valid no change", int'(sw_out), 0);
    sample(2000, 31, "R8 latency one cycle");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule